// File: doc/BRIEF.md
# Register Scoreboard for Overlapped Loads

This block keeps one busy flag for each of the thirty-two 32-bit general registers. It lets an in-order issue stage send later instructions while memory loads are still in flight. Each cycle the issue stage presents at most one instruction: two optional source register numbers, an optional destination register number, and flags for load, condition-set and condition-read. The block answers in the same cycle with a stall, or with an accept. The hazard test uses only registered state. No compiler-inserted delay is needed, because the stall enforces every ordering rule.

An accepted load marks its destination busy. A later load-return strobe that names the register clears the mark. A separate two-state machine tracks an outstanding condition-code producer. Its states are `COND_IDLE` and `COND_PEND`. The transition `COND_IDLE -> COND_PEND` is taken when a condition-setting instruction is accepted. The transition `COND_PEND -> COND_IDLE` is taken on the condition-complete strobe. A counter limits the number of outstanding loads to a parameter.

Top module: `load_scoreboard`

## Requirements
- R1: After reset, `busy_mask` is all zero, `cond_pending` is 0, and no request stalls for lack of load slots.
- R2: `iss_accept` is high exactly when `iss_valid` is high and `iss_stall` is low. `iss_stall` is low whenever `iss_valid` is low.
- R3: An accepted load with `iss_dst_en` set makes `busy_mask[iss_dst]` high from the next cycle. Bit i of `busy_mask` belongs to register i.
- R4: `ret_valid` with `ret_reg` clears that register's busy bit from the next cycle. A return that names a register which is not busy changes nothing, and it frees no load slot.
- R5: A request whose enabled source register (`iss_src_a` or `iss_src_b`) is busy is stalled (read-after-write).
- R6: A request whose enabled destination register is busy is stalled (write-after-write). This applies to loads as well.
- R7: A request that touches no busy register and no pending condition is accepted, even while loads or a condition result are outstanding.
- R8: An accepted request with `iss_sets_cond` makes `cond_pending` high from the next cycle. While `cond_pending` is high, a request with `iss_reads_cond` or `iss_sets_cond` is stalled.
- R9: `cond_done` while pending returns `cond_pending` to 0 on the next cycle. `cond_done` while idle has no effect.
- R10: If a return and an accepted load name the same register in the same cycle, the register is busy in the next cycle (the set wins).
- R11: With `MAX_LOADS` loads outstanding, a further load is stalled and non-loads still flow. The number of outstanding loads always equals the number of busy bits.
- R12: Register 0 is tracked exactly like every other register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | An instruction requests issue |
| iss_is_load | input | 1 | Request is a memory load |
| iss_sets_cond | input | 1 | Request produces the condition code |
| iss_reads_cond | input | 1 | Request consumes the condition code |
| iss_src_a_en | input | 1 | First source is used |
| iss_src_a | input | IDXW (5) | First source register number |
| iss_src_b_en | input | 1 | Second source is used |
| iss_src_b | input | IDXW (5) | Second source register number |
| iss_dst_en | input | 1 | Destination is written |
| iss_dst | input | IDXW (5) | Destination register number |
| ret_valid | input | 1 | A load's data is returning |
| ret_reg | input | IDXW (5) | Register the returning load writes |
| cond_done | input | 1 | The pending condition result has completed |
| iss_stall | output | 1 | Request must be held |
| iss_accept | output | 1 | Request issues this cycle |
| busy_mask | output | NREG (32) | Per-register busy flags |
| cond_pending | output | 1 | Condition result outstanding |

## Verification
A wrong busy bit appears on `busy_mask` one cycle after the update that caused it. In the same cycle it also shows as a spurious or missing `iss_stall` for any request that names that register. A slot counter that has drifted shows only at the limit: a fourth or fifth load is stalled or accepted when it should not be, or a return to an idle register frees a slot. A wrong condition-machine state shows on `cond_pending` on the next cycle, and as a wrong stall for condition readers. The bench uses a queue-based model and compares all four outputs on every cycle, so each fault is reported in the cycle where it first becomes visible.

// File: rtl/sb_pkg.sv
package sb_pkg;

    typedef enum logic {
        COND_IDLE = 1'b0,
        COND_PEND = 1'b1
    } cond_state_e;

endpackage

// File: rtl/sb_busy_bits.sv
module sb_busy_bits #(
    parameter int NREG = 32,
    localparam int IDXW = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            set_en,
    input  logic [IDXW-1:0] set_idx,
    input  logic            clr_en,
    input  logic [IDXW-1:0] clr_idx,
    output logic [NREG-1:0] busy
);

    for (genvar i = 0; i < NREG; i++) begin : g_bit
        logic hit_set;
        logic hit_clr;

        always_comb begin
            hit_set = set_en && (set_idx == IDXW'(i));
            hit_clr = clr_en && (clr_idx == IDXW'(i));
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                busy[i] <= 1'b0;
            end else if (hit_set) begin
                busy[i] <= 1'b1;
            end else if (hit_clr) begin
                busy[i] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/sb_ld_count.sv
module sb_ld_count #(
    parameter int MAX_LOADS = 4,
    localparam int CW = $clog2(MAX_LOADS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    input  logic          dec,
    output logic [CW-1:0] count,
    output logic          full
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (inc && !dec) begin
            count <= count + CW'(1);
        end else if (dec && !inc && (count != '0)) begin
            count <= count - CW'(1);
        end
    end

    always_comb begin
        full = (count == CW'(MAX_LOADS));
    end

endmodule

// File: rtl/sb_cond_fsm.sv
module sb_cond_fsm
    import sb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_acc,
    input  logic done,
    output logic pending
);

    cond_state_e state_q;
    cond_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= COND_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        pending = 1'b0;
        unique case (state_q)
            COND_IDLE: begin
                pending = 1'b0;
                if (set_acc) begin
                    state_d = COND_PEND;
                end
            end
            COND_PEND: begin
                pending = 1'b1;
                if (done) begin
                    state_d = COND_IDLE;
                end
            end
            default: begin
                state_d = COND_IDLE;
            end
        endcase
    end

endmodule

// File: rtl/sb_hazard.sv
module sb_hazard #(
    parameter int NREG = 32,
    localparam int IDXW = $clog2(NREG)
) (
    input  logic [NREG-1:0] busy,
    input  logic            cond_pend,
    input  logic            slots_full,
    input  logic            valid,
    input  logic            is_load,
    input  logic            sets_cond,
    input  logic            reads_cond,
    input  logic            src_a_en,
    input  logic [IDXW-1:0] src_a,
    input  logic            src_b_en,
    input  logic [IDXW-1:0] src_b,
    input  logic            dst_en,
    input  logic [IDXW-1:0] dst,
    output logic            stall
);

    logic raw_hit;
    logic waw_hit;
    logic cc_hit;
    logic cap_hit;

    always_comb begin
        raw_hit = (src_a_en && busy[src_a]) || (src_b_en && busy[src_b]);
        waw_hit = dst_en && busy[dst];
        cc_hit  = (reads_cond || sets_cond) && cond_pend;
        cap_hit = is_load && slots_full;
        stall   = valid && (raw_hit || waw_hit || cc_hit || cap_hit);
    end

endmodule

// File: rtl/load_scoreboard.sv
module load_scoreboard #(
    parameter int NREG      = 32,
    parameter int MAX_LOADS = 4,
    localparam int IDXW     = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            iss_valid,
    input  logic            iss_is_load,
    input  logic            iss_sets_cond,
    input  logic            iss_reads_cond,
    input  logic            iss_src_a_en,
    input  logic [IDXW-1:0] iss_src_a,
    input  logic            iss_src_b_en,
    input  logic [IDXW-1:0] iss_src_b,
    input  logic            iss_dst_en,
    input  logic [IDXW-1:0] iss_dst,
    input  logic            ret_valid,
    input  logic [IDXW-1:0] ret_reg,
    input  logic            cond_done,
    output logic            iss_stall,
    output logic            iss_accept,
    output logic [NREG-1:0] busy_mask,
    output logic            cond_pending
);

    localparam int CW = $clog2(MAX_LOADS + 1);

    logic          slots_full;
    logic [CW-1:0] ld_cnt;
    logic          ld_set;
    logic          ld_free;

    always_comb begin
        iss_accept = iss_valid && !iss_stall;
        ld_set     = iss_accept && iss_is_load && iss_dst_en;
        ld_free    = ret_valid && busy_mask[ret_reg];
    end

    sb_hazard #(.NREG(NREG)) u_hazard (
        .busy       (busy_mask),
        .cond_pend  (cond_pending),
        .slots_full (slots_full),
        .valid      (iss_valid),
        .is_load    (iss_is_load),
        .sets_cond  (iss_sets_cond),
        .reads_cond (iss_reads_cond),
        .src_a_en   (iss_src_a_en),
        .src_a      (iss_src_a),
        .src_b_en   (iss_src_b_en),
        .src_b      (iss_src_b),
        .dst_en     (iss_dst_en),
        .dst        (iss_dst),
        .stall      (iss_stall)
    );

    sb_busy_bits #(.NREG(NREG)) u_busy (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (ld_set),
        .set_idx (iss_dst),
        .clr_en  (ret_valid),
        .clr_idx (ret_reg),
        .busy    (busy_mask)
    );

    sb_ld_count #(.MAX_LOADS(MAX_LOADS)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (ld_set),
        .dec   (ld_free),
        .count (ld_cnt),
        .full  (slots_full)
    );

    sb_cond_fsm u_cond (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_acc (iss_accept && iss_sets_cond),
        .done    (cond_done),
        .pending (cond_pending)
    );

endmodule

// File: rtl/sb_chk.sv
module sb_chk #(
    parameter int NREG      = 32,
    parameter int MAX_LOADS = 4,
    localparam int IDXW     = $clog2(NREG),
    localparam int CW       = $clog2(MAX_LOADS + 1)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            iss_valid,
    input logic            iss_is_load,
    input logic            iss_sets_cond,
    input logic            iss_reads_cond,
    input logic            iss_src_a_en,
    input logic [IDXW-1:0] iss_src_a,
    input logic            iss_src_b_en,
    input logic [IDXW-1:0] iss_src_b,
    input logic            iss_dst_en,
    input logic [IDXW-1:0] iss_dst,
    input logic            ret_valid,
    input logic [IDXW-1:0] ret_reg,
    input logic            cond_done,
    input logic            iss_stall,
    input logic            iss_accept,
    input logic [NREG-1:0] busy_mask,
    input logic            cond_pending,
    input logic [CW-1:0]   ld_cnt
);

    // R3
    load_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_accept && iss_is_load && iss_dst_en) |=> busy_mask[$past(iss_dst)]);

    // R4
    ret_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && !(iss_accept && iss_is_load && iss_dst_en && (iss_dst == ret_reg)))
        |=> !busy_mask[$past(ret_reg)]);

    // R5
    raw_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && ((iss_src_a_en && busy_mask[iss_src_a]) ||
                       (iss_src_b_en && busy_mask[iss_src_b]))) |-> iss_stall);

    // R6
    waw_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_dst_en && busy_mask[iss_dst]) |-> iss_stall);

    // R8
    cond_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && (iss_reads_cond || iss_sets_cond) && cond_pending) |-> iss_stall);

    // R9
    cond_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_done && cond_pending) |=> !cond_pending);

    // R10
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && iss_accept && iss_is_load && iss_dst_en && (iss_dst == ret_reg))
        |=> busy_mask[$past(iss_dst)]);

    // R11
    slot_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_cnt == CW'(MAX_LOADS)) |-> !(iss_accept && iss_is_load));

    // R11
    slot_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_cnt == CW'($countones(busy_mask)));

endmodule

bind load_scoreboard sb_chk #(.NREG(NREG), .MAX_LOADS(MAX_LOADS)) u_sb_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .iss_valid      (iss_valid),
    .iss_is_load    (iss_is_load),
    .iss_sets_cond  (iss_sets_cond),
    .iss_reads_cond (iss_reads_cond),
    .iss_src_a_en   (iss_src_a_en),
    .iss_src_a      (iss_src_a),
    .iss_src_b_en   (iss_src_b_en),
    .iss_src_b      (iss_src_b),
    .iss_dst_en     (iss_dst_en),
    .iss_dst        (iss_dst),
    .ret_valid      (ret_valid),
    .ret_reg        (ret_reg),
    .cond_done      (cond_done),
    .iss_stall      (iss_stall),
    .iss_accept     (iss_accept),
    .busy_mask      (busy_mask),
    .cond_pending   (cond_pending),
    .ld_cnt         (ld_cnt)
);

// File: tb/tb_load_scoreboard.sv
module tb_load_scoreboard;

    localparam int CLK_PERIOD = 10;
    localparam int NREG       = 32;
    localparam int MAXL       = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       iss_valid = 0, iss_is_load = 0, iss_sets_cond = 0, iss_reads_cond = 0;
    logic       iss_src_a_en = 0, iss_src_b_en = 0, iss_dst_en = 0;
    logic [4:0] iss_src_a = 0, iss_src_b = 0, iss_dst = 0, ret_reg = 0;
    logic       ret_valid = 0, cond_done = 0;
    logic       iss_stall, iss_accept, cond_pending;
    logic [NREG-1:0] busy_mask;

    int compared = 0;
    int mismatched = 0;
    int q[$];
    bit mcond = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    load_scoreboard #(.NREG(NREG), .MAX_LOADS(MAXL)) dut (
        .clk(clk), .rst_n(rst_n),
        .iss_valid(iss_valid), .iss_is_load(iss_is_load),
        .iss_sets_cond(iss_sets_cond), .iss_reads_cond(iss_reads_cond),
        .iss_src_a_en(iss_src_a_en), .iss_src_a(iss_src_a),
        .iss_src_b_en(iss_src_b_en), .iss_src_b(iss_src_b),
        .iss_dst_en(iss_dst_en), .iss_dst(iss_dst),
        .ret_valid(ret_valid), .ret_reg(ret_reg), .cond_done(cond_done),
        .iss_stall(iss_stall), .iss_accept(iss_accept),
        .busy_mask(busy_mask), .cond_pending(cond_pending)
    );

    function automatic bit mbusy(int r);
        foreach (q[i]) if (q[i] == r) return 1'b1;
        return 1'b0;
    endfunction

    function automatic logic [NREG-1:0] mmask();
        logic [NREG-1:0] m = '0;
        foreach (q[i]) m[q[i]] = 1'b1;
        return m;
    endfunction

    // One cycle: drive at the falling edge, compare before the rising edge, then advance the model.
    task automatic step(input string req, input bit v, ld, sc, rc,
                        input bit ae, input int a, input bit be, input int b,
                        input bit de, input int d, input bit rv, input int r, input bit cd);
        bit es, ea;
        @(negedge clk);
        iss_valid = v; iss_is_load = ld; iss_sets_cond = sc; iss_reads_cond = rc;
        iss_src_a_en = ae; iss_src_a = 5'(a); iss_src_b_en = be; iss_src_b = 5'(b);
        iss_dst_en = de; iss_dst = 5'(d); ret_valid = rv; ret_reg = 5'(r); cond_done = cd;
        #1;
        es = v && ((ae && mbusy(a)) || (be && mbusy(b)) || (de && mbusy(d)) ||
                   ((rc || sc) && mcond) || (ld && q.size() == MAXL));
        ea = v && !es;
        compared++;
        if (iss_stall !== es || iss_accept !== ea || busy_mask !== mmask() || cond_pending !== mcond) begin
            mismatched++;
            $display("FAIL %s: stall/acc/mask/cond = %b/%b/%h/%b expected %b/%b/%h/%b",
                     req, iss_stall, iss_accept, busy_mask, cond_pending, es, ea, mmask(), mcond);
        end
        @(posedge clk);
        if (rv) begin
            for (int i = 0; i < q.size(); i++) if (q[i] == r) begin q.delete(i); break; end
        end
        if (ea && ld && de) q.push_back(d);
        if (cd) mcond = 1'b0;
        if (ea && sc) mcond = 1'b1;
    endtask

    task automatic idle(input string req);
        step(req, 0,0,0,0, 0,0, 0,0, 0,0, 0,0, 0);
    endtask
    task automatic load(input string req, input int d);
        step(req, 1,1,0,0, 0,0, 0,0, 1,d, 0,0, 0);
    endtask
    task automatic alu(input string req, input int a, input int b, input int d);
        step(req, 1,0,0,0, 1,a, 1,b, 1,d, 0,0, 0);
    endtask
    task automatic ret(input string req, input int r);
        step(req, 0,0,0,0, 0,0, 0,0, 0,0, 1,r, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        mismatched++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle("R1"); idle("R2");
        // R3 / R7 / R5 / R6
        load("R3", 5);
        alu("R7", 6, 7, 8);
        alu("R5", 5, 7, 9);
        alu("R6", 1, 2, 5);
        load("R6", 5);
        ret("R4", 5);
        alu("R5", 5, 5, 11);
        // R12: register 0
        load("R12", 0);
        step("R12", 1,0,0,0, 0,0, 1,0, 1,3, 0,0, 0);
        ret("R12", 0);
        step("R12", 1,0,0,0, 1,0, 1,0, 0,0, 0,0, 0);
        // R8 / R9
        step("R8", 1,0,1,0, 1,1, 0,0, 1,2, 0,0, 0);
        step("R8", 1,0,0,1, 0,0, 0,0, 1,4, 0,0, 0);
        alu("R7", 3, 4, 6);
        step("R8", 1,0,1,0, 0,0, 0,0, 0,0, 0,0, 0);
        step("R9", 0,0,0,0, 0,0, 0,0, 0,0, 0,0, 1);
        step("R9", 0,0,0,0, 0,0, 0,0, 0,0, 0,0, 1);
        step("R8", 1,0,0,1, 0,0, 0,0, 1,4, 0,0, 0);
        // R10: set wins over same-cycle return
        step("R10", 1,1,0,0, 0,0, 0,0, 1,9, 1,9, 0);
        idle("R10");
        ret("R10", 9);
        // R11: slot limit
        load("R11", 1); load("R11", 2); load("R11", 3); load("R11", 4);
        load("R11", 10);
        alu("R11", 12, 13, 14);
        ret("R4", 20);
        load("R11", 10);
        ret("R11", 2);
        load("R11", 10);
        idle("R11");
        ret("R4", 1); ret("R4", 3); ret("R4", 4); ret("R4", 10);
        step("R9", 1,0,1,0, 0,0, 0,0, 0,0, 0,0, 1);
        idle("R9");
        step("R9", 0,0,0,0, 0,0, 0,0, 0,0, 0,0, 1);
        // Mixed traffic on a narrow register range
        for (int n = 0; n < 2000; n++) begin
            step("R2", $urandom_range(0,3) != 0, $urandom_range(0,1), $urandom_range(0,7) == 0,
                 $urandom_range(0,3) == 0, $urandom_range(0,1), $urandom_range(0,7),
                 $urandom_range(0,1), $urandom_range(0,7), $urandom_range(0,1), $urandom_range(0,7),
                 $urandom_range(0,2) == 0, $urandom_range(0,7), $urandom_range(0,5) == 0);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule